// File: doc/BRIEF.md
# Boot Remap and Reset Controller

This block owns two things in a small processor subsystem: which memory answers at the bottom of the program address space, and the processor's reset line. Out of power-on the lowest addresses decode to a boot ROM. The ROM code loads a program into a program RAM and then asks for a remap. In the same clock edge the block raises the processor reset and switches the decode so that the RAM answers everywhere and the ROM is gone. When the reset window ends, the processor starts again from address zero, which is now in RAM.

A supervising host can force a reset at any moment and choose the mapping the processor wakes into. While the RAM program runs it must pulse a heartbeat. If the heartbeat pulses stop for a set number of cycles, the block records a sticky fault and reboots the processor into the ROM mapping. Every reset window, whatever caused it, lasts the same parameterised number of cycles. That count stands for a 10 ms hold at the system clock.

Top module: `boot_remap_ctrl`

## Requirements
- R1: While rst_ni is low and for exactly RESET_CYCLES cycles after it rises, proc_reset_o is 1; map_sel_o is 0 (ROM mapping) and fault_o is 0 out of reset.
- R2: With map_sel_o = 0, a fetch address below ROM_BYTES gives rom_sel_o = 1 and ram_sel_o = 0; any other address gives rom_sel_o = 0 and ram_sel_o = 1.
- R3: A remap_req_i pulse seen while proc_reset_o is 0 sets map_sel_o to 1 and proc_reset_o to 1 at the same clock edge.
- R4: Each accepted reset event keeps proc_reset_o at 1 for exactly RESET_CYCLES cycles, counted from the edge that accepted it.
- R5: With map_sel_o = 1, rom_sel_o is 0 and ram_sel_o is 1 for every fetch address.
- R6: remap_req_i is ignored while proc_reset_o is 1: it changes neither the mapping nor the length of the current reset window.
- R7: host_force_i is accepted in any state, including during a reset window. It loads map_sel_o from host_map_i (0 = ROM, 1 = RAM) and starts a fresh full reset window.
- R8: When host_force_i and remap_req_i arrive in the same cycle, the host request decides the mapping.
- R9: With map_sel_o = 1 and proc_reset_o = 0, HB_TIMEOUT consecutive cycles without heartbeat_i raise proc_reset_o, clear map_sel_o to 0 and set fault_o, all at the same edge. A heartbeat pulse restarts the count.
- R10: The heartbeat timeout never fires in the ROM mapping or during a reset window.
- R11: fault_o stays set until a fault_clr_i pulse, and reset events do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| remap_req_i | input | 1 | Processor request to switch to the RAM mapping |
| host_force_i | input | 1 | Host request for an immediate reset |
| host_map_i | input | 1 | Mapping chosen by a host reset (0 ROM, 1 RAM) |
| heartbeat_i | input | 1 | Periodic liveness pulse from the processor |
| fault_clr_i | input | 1 | Host clear for the sticky fault flag |
| fetch_addr_i | input | ADDR_W | Processor program fetch address |
| proc_reset_o | output | 1 | Processor reset, active high |
| map_sel_o | output | 1 | Current mapping (0 ROM, 1 RAM) |
| rom_sel_o | output | 1 | Boot ROM select for the fetch address |
| ram_sel_o | output | 1 | Program RAM select for the fetch address |
| fault_o | output | 1 | Sticky heartbeat-loss fault |

## Verification
A wrong mapping register shows up on the very next combinational decode of the fetch address, so the checks compare ROM and RAM selects at both edges of the ROM window. A reset counter that is off by one shows up only when the window ends, RESET_CYCLES cycles later, so every window is timed edge by edge, including one that is restarted partway through. A watchdog counter error shows up only at the expiry cycle, HB_TIMEOUT cycles after the last heartbeat, so that interval is counted exactly. The bench also checks that the watchdog stays silent in the ROM mapping.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic {
    MAP_ROM = 1'b0,
    MAP_RAM = 1'b1
  } map_e;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_HOST  = 2'd1,
    EV_WDOG  = 2'd2,
    EV_REMAP = 2'd3
  } rst_event_e;

endpackage

// File: rtl/brc_reset_timer.sv
module brc_reset_timer #(
  parameter int RESET_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o
);

  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RESET_CYCLES);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // The counter reloads on any accepted event and otherwise runs down to zero.
  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - ONE;
    end
  end

  // Power-on loads a full window, so the processor is held after reset release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active_o = (cnt_q != '0);

endmodule

// File: rtl/brc_hb_wdog.sv
module brc_hb_wdog #(
  parameter int HB_TIMEOUT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic beat_i,
  output logic expired_o
);

  localparam int CNT_W = $clog2(HB_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HB_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             expired;

  // Expiry falls in the HB_TIMEOUT-th armed cycle that has no beat.
  always_comb begin
    expired = arm_i && !beat_i && (cnt_q == LAST);
    if (!arm_i || beat_i || expired) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = expired;

endmodule

// File: rtl/brc_addr_decode.sv
module brc_addr_decode #(
  parameter int ADDR_W    = 16,
  parameter int ROM_BYTES = 4096
) (
  input  logic              map_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rom_sel_o,
  output logic              ram_sel_o
);

  localparam bit ROM_POW2 = (ROM_BYTES > 0) && ((ROM_BYTES & (ROM_BYTES - 1)) == 0);
  localparam int ROM_AW   = (ROM_BYTES > 1) ? $clog2(ROM_BYTES) : 1;

  logic in_rom_window;

  generate
    if (ROM_POW2 && (ROM_AW < ADDR_W)) begin : g_pow2
      // A power-of-two window only needs the upper address bits to be zero.
      assign in_rom_window = (addr_i[ADDR_W-1:ROM_AW] == '0);
    end else begin : g_cmp
      localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W + 1)'(ROM_BYTES);
      assign in_rom_window = ({1'b0, addr_i} < ROM_LIM);
    end
  endgenerate

  // In the RAM mapping the ROM is hidden everywhere.
  always_comb begin
    rom_sel_o = (map_i == brc_pkg::MAP_ROM) && in_rom_window;
    ram_sel_o = !rom_sel_o;
  end

endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int ROM_BYTES    = 4096,
  parameter int RESET_CYCLES = 500000,
  parameter int HB_TIMEOUT   = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              remap_req_i,
  input  logic              host_force_i,
  input  logic              host_map_i,
  input  logic              heartbeat_i,
  input  logic              fault_clr_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              proc_reset_o,
  output logic              map_sel_o,
  output logic              rom_sel_o,
  output logic              ram_sel_o,
  output logic              fault_o
);

  import brc_pkg::*;

  map_e       map_q, map_d;
  rst_event_e ev;
  logic       map_en;
  logic       fault_q, fault_d;
  logic       in_reset;
  logic       wd_arm;
  logic       wd_expired;
  logic       remap_ok;

  // Priority: host override, then heartbeat loss, then the processor request.
  always_comb begin
    remap_ok = remap_req_i && !in_reset;
    if (host_force_i)      ev = EV_HOST;
    else if (wd_expired)   ev = EV_WDOG;
    else if (remap_ok)     ev = EV_REMAP;
    else                   ev = EV_NONE;
  end

  always_comb begin
    map_en = (ev != EV_NONE);
    unique case (ev)
      EV_HOST:  map_d = map_e'(host_map_i);
      EV_WDOG:  map_d = MAP_ROM;
      EV_REMAP: map_d = MAP_RAM;
      default:  map_d = map_q;
    endcase
  end

  always_comb begin
    fault_d = fault_q;
    if (wd_expired)       fault_d = 1'b1;
    else if (fault_clr_i) fault_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= MAP_ROM;
    end else if (map_en) begin
      map_q <= map_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_d;
    end
  end

  // The mapping change and the reset reload share the same event, so they land on one edge.
  brc_reset_timer #(
    .RESET_CYCLES(RESET_CYCLES)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (map_en),
    .active_o(in_reset)
  );

  assign wd_arm = (map_q == MAP_RAM) && !in_reset;

  brc_hb_wdog #(
    .HB_TIMEOUT(HB_TIMEOUT)
  ) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (wd_arm),
    .beat_i   (heartbeat_i),
    .expired_o(wd_expired)
  );

  brc_addr_decode #(
    .ADDR_W   (ADDR_W),
    .ROM_BYTES(ROM_BYTES)
  ) u_dec (
    .map_i    (map_q),
    .addr_i   (fetch_addr_i),
    .rom_sel_o(rom_sel_o),
    .ram_sel_o(ram_sel_o)
  );

  assign proc_reset_o = in_reset;
  assign map_sel_o    = map_q;
  assign fault_o      = fault_q;

endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int RESET_CYCLES = 500000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic remap_req_i,
  input logic host_force_i,
  input logic host_map_i,
  input logic fault_clr_i,
  input logic proc_reset_o,
  input logic map_sel_o,
  input logic rom_sel_o,
  input logic fault_o,
  input logic wd_expired
);

  // Length of the current reset window; the cycle out of power-on counts as the first.
  logic [31:0] hi_cnt;
  logic        trig;

  assign trig = host_force_i || wd_expired || (remap_req_i && !proc_reset_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= 32'd1;
    end else if (trig) begin
      hi_cnt <= 32'd1;
    end else if (proc_reset_o) begin
      hi_cnt <= hi_cnt + 32'd1;
    end else begin
      hi_cnt <= 32'd0;
    end
  end

  assert_remap_atomic_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_req_i && !proc_reset_o && !host_force_i && !wd_expired) |=> (map_sel_o && proc_reset_o));

  assert_window_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(proc_reset_o) |-> ($past(hi_cnt) == RESET_CYCLES));

  assert_rom_hidden_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_sel_o |-> !rom_sel_o);

  assert_remap_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_reset_o && !host_force_i) |=> $stable(map_sel_o));

  assert_host_map_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_force_i |=> (proc_reset_o && (map_sel_o == $past(host_map_i))));

  assert_wdog_reboot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_expired && !host_force_i) |=> (proc_reset_o && !map_sel_o && fault_o));

  assert_wdog_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!map_sel_o || proc_reset_o) |-> !wd_expired);

  assert_fault_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_clr_i) |=> fault_o);

endmodule

bind boot_remap_ctrl brc_checker #(
  .RESET_CYCLES(RESET_CYCLES)
) u_brc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .remap_req_i (remap_req_i),
  .host_force_i(host_force_i),
  .host_map_i  (host_map_i),
  .fault_clr_i (fault_clr_i),
  .proc_reset_o(proc_reset_o),
  .map_sel_o   (map_sel_o),
  .rom_sel_o   (rom_sel_o),
  .fault_o     (fault_o),
  .wd_expired  (wd_expired)
);

// File: tb/boot_remap_ctrl_tb.sv
module boot_remap_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int ROMB = 4096;
  localparam int RC   = 8;
  localparam int HB   = 20;

  typedef struct packed {
    logic          map;
    logic [AW-1:0] addr;
    logic          rom;
  } dec_vec_t;

  // Decode vectors: ROM-mapping entries first, then RAM-mapping entries.
  localparam dec_vec_t VECS [8] = '{
    '{1'b0, 16'h0000, 1'b1},
    '{1'b0, 16'h0FFF, 1'b1},
    '{1'b0, 16'h1000, 1'b0},
    '{1'b0, 16'hFFFF, 1'b0},
    '{1'b1, 16'h0000, 1'b0},
    '{1'b1, 16'h0FFF, 1'b0},
    '{1'b1, 16'h0800, 1'b0},
    '{1'b1, 16'hFFFF, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          remap_req, host_force, host_map, heartbeat, fault_clr;
  logic [AW-1:0] fetch_addr;
  logic          proc_reset, map_sel, rom_sel, ram_sel, fault;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  boot_remap_ctrl #(
    .ADDR_W      (AW),
    .ROM_BYTES   (ROMB),
    .RESET_CYCLES(RC),
    .HB_TIMEOUT  (HB)
  ) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .remap_req_i (remap_req),
    .host_force_i(host_force),
    .host_map_i  (host_map),
    .heartbeat_i (heartbeat),
    .fault_clr_i (fault_clr),
    .fetch_addr_i(fetch_addr),
    .proc_reset_o(proc_reset),
    .map_sel_o   (map_sel),
    .rom_sel_o   (rom_sel),
    .ram_sel_o   (ram_sel),
    .fault_o     (fault)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Counts negedges with proc_reset high, starting at the current one.
  task automatic measure_reset(output int n);
    n = 0;
    while (proc_reset && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_remap();
    int n;
    remap_req = 1'b1;
    @(negedge clk);
    remap_req = 1'b0;
    chk("R3", "map_sel after remap", int'(map_sel), 1);
    chk("R3", "proc_reset after remap", int'(proc_reset), 1);
    measure_reset(n);
    chk("R4", "remap window length", n, RC);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit any_rst;
    rst_ni = 1'b0; remap_req = 1'b0; host_force = 1'b0; host_map = 1'b0;
    heartbeat = 1'b0; fault_clr = 1'b0; fetch_addr = '0;

    // R1: reset state and power-on window
    repeat (3) @(negedge clk);
    chk("R1", "proc_reset in reset", int'(proc_reset), 1);
    chk("R1", "map_sel in reset", int'(map_sel), 0);
    chk("R1", "fault in reset", int'(fault), 0);
    rst_ni = 1'b1;
    measure_reset(n);
    chk("R1", "power-on window length", n, RC);
    chk("R1", "fault after power-on", int'(fault), 0);

    // R2 / R5: decode vectors, remap between the two groups
    for (int i = 0; i < 8; i++) begin
      if (VECS[i].map != map_sel) do_remap();
      fetch_addr = VECS[i].addr;
      #1;
      chk(VECS[i].map ? "R5" : "R2", "rom_sel", int'(rom_sel), int'(VECS[i].rom));
      chk(VECS[i].map ? "R5" : "R2", "ram_sel", int'(ram_sel), int'(!VECS[i].rom));
    end

    // R7 then R6: host reset into ROM, remap request inside the window is ignored
    @(negedge clk);
    host_map = 1'b0; host_force = 1'b1;
    @(negedge clk);
    host_force = 1'b0;
    chk("R7", "map_sel after host force", int'(map_sel), 0);
    chk("R7", "proc_reset after host force", int'(proc_reset), 1);
    remap_req = 1'b1;
    @(negedge clk);
    remap_req = 1'b0;
    chk("R6", "map_sel after remap in reset", int'(map_sel), 0);
    measure_reset(n);
    chk("R6", "window not restarted", n + 1, RC);

    // R7: a second host force inside a window restarts it
    host_map = 1'b1; host_force = 1'b1;
    @(negedge clk);
    host_force = 1'b0;
    chk("R7", "map_sel host RAM", int'(map_sel), 1);
    repeat (3) @(negedge clk);
    host_map = 1'b0; host_force = 1'b1;
    @(negedge clk);
    host_force = 1'b0;
    chk("R7", "map_sel host ROM in reset", int'(map_sel), 0);
    measure_reset(n);
    chk("R7", "restarted window length", n, RC);

    // R8: host force and remap request in one cycle
    host_map = 1'b0; host_force = 1'b1; remap_req = 1'b1;
    @(negedge clk);
    host_force = 1'b0; remap_req = 1'b0;
    chk("R8", "map_sel host wins", int'(map_sel), 0);
    chk("R8", "proc_reset on collision", int'(proc_reset), 1);
    measure_reset(n);
    chk("R8", "collision window length", n, RC);

    // R10: no heartbeat in the ROM mapping causes nothing
    any_rst = 1'b0;
    repeat (50) begin
      @(negedge clk);
      any_rst |= proc_reset;
    end
    chk("R10", "reset in ROM mapping without beats", int'(any_rst), 0);
    chk("R10", "fault in ROM mapping", int'(fault), 0);

    // R9: beats keep the RAM program alive
    do_remap();
    any_rst = 1'b0;
    for (int i = 0; i < 60; i++) begin
      heartbeat = (i % 5 == 0);
      @(negedge clk);
      any_rst |= proc_reset;
    end
    chk("R9", "reset while beating", int'(any_rst), 0);
    chk("R9", "fault while beating", int'(fault), 0);
    chk("R9", "map_sel while beating", int'(map_sel), 1);

    // R9: exact timeout after the last beat
    heartbeat = 1'b1;
    @(negedge clk);
    heartbeat = 1'b0;
    n = 0;
    while (!proc_reset && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R9", "cycles to timeout", n, HB);
    chk("R9", "map_sel after timeout", int'(map_sel), 0);
    chk("R9", "fault after timeout", int'(fault), 1);
    measure_reset(n);
    chk("R4", "watchdog window length", n, RC);

    // R11: fault survives a host reset, clears only on fault_clr
    host_map = 1'b1; host_force = 1'b1;
    @(negedge clk);
    host_force = 1'b0;
    chk("R11", "fault after host reset", int'(fault), 1);
    measure_reset(n);
    chk("R11", "fault after window", int'(fault), 1);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    chk("R11", "fault after clear", int'(fault), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule